// File: doc/BRIEF.md
# Link Power Status Supervisor

This block sits between the link-power-status input from a link-layer controller and the PHY-to-link interface. It counts how many reference-clock cycles the status line stays low. A brief dropout that passes a lower threshold but does not reach an upper one produces a single-cycle interface-reset pulse. A dropout that reaches the upper threshold turns the interface off to save power. Repeating traffic on the cable is handled elsewhere and is not affected. When the status line returns after a shutdown, the interface is switched back on after a short fixed settling count.

While the status line is low, the block can wake the link. It does this by driving a square wave on its link-on output. The wave starts when a link-on packet addressed to this node arrives, or when one of the interrupt conditions from the register block is present. It runs until the status line goes high again. A bus reset stops the wave only when no interrupt condition is present. The status line is sampled synchronously. All thresholds are derived from the reference-clock frequency.

Top module: `link_power_supervisor`

## Requirements
- R1: While `rst_n` is low at a clock edge, all three outputs are low from the next cycle. All timers restart from zero.
- R2: Let `lps` return high after N consecutive low samples, with SHORT_CYC <= N < LONG_CYC (59 and 1229 by default), while `if_enable` is high. Then `if_reset` is high for exactly one cycle, in the cycle after the first high sample. A gap shorter than SHORT_CYC gives no pulse.
- R3: After LONG_CYC consecutive low samples of `lps`, `if_enable` is low from the next cycle. No reset pulse follows when `lps` returns.
- R4: While `if_enable` is low, it goes high after INIT_CYC (64) consecutive high samples of `lps`. This also applies after reset. Any low sample restarts the count.
- R5: `link_on` is low whenever the wake activity is off. It is never high in the cycle after a high sample of `lps`.
- R6: Wake activity starts at a low sample of `lps` when any of these is true: `linkon_pkt` is high; `port_event` is high; or any of `timeout_flag`, `pwr_fail_flag`, `loop_flag` is high together with `resume_int`. If `timeout_flag` is high without `resume_int`, wake activity does not start.
- R7: Once started, wake activity continues after every cause is removed. It stops only when `lps` is sampled high, or as R8 allows.
- R8: A `bus_reset` sample while `lps` is low ends wake activity if no interrupt cause (R6, excluding the packet) is present in that cycle. If an interrupt cause is present, wake activity continues.
- R9: An interrupt cause that is present while `lps` is high starts wake activity at the first low sample of `lps`.
- R10: When active, `link_on` is low for the first DIV/2 (4) cycles, then high for DIV/2 cycles. The period is DIV (8) cycles.
- R11: A `linkon_pkt` strobe while `lps` is high is ignored, and `link_on` stays low after `lps` later goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lps | input | 1 | Link power status, high when the link is powered |
| linkon_pkt | input | 1 | Strobe: link-on packet for this node received |
| bus_reset | input | 1 | Strobe: bus reset occurred |
| port_event | input | 1 | Port event interrupt flag |
| timeout_flag | input | 1 | Arbitration timeout interrupt flag |
| pwr_fail_flag | input | 1 | Cable power fail interrupt flag |
| loop_flag | input | 1 | Loop detect interrupt flag |
| resume_int | input | 1 | Resume interrupt enable |
| if_reset | output | 1 | One-cycle PHY-link interface reset pulse |
| if_enable | output | 1 | PHY-link interface enable |
| link_on | output | 1 | Link wake square wave |

## Verification
A wrong gap count shows up as a misplaced or missing `if_reset` pulse, or as a premature or late fall of `if_enable`. Either is visible within one cycle of the threshold crossing. A wrong wake latch shows up as `link_on` starting, continuing or stopping in the wrong cycle. The divider phase shows up as a shifted edge within one period. The bench compares every output on every cycle against a behavioural model. Any divergence is therefore reported in the cycle it first appears.

// File: rtl/link_power_supervisor.sv
module link_power_supervisor #(
  parameter int REF_HZ   = 49_152_000,
  parameter int SHORT_NS = 1_200,
  parameter int LONG_NS  = 25_000,
  parameter int INIT_CYC = 64,
  parameter int DIV      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lps,
  input  logic linkon_pkt,
  input  logic bus_reset,
  input  logic port_event,
  input  logic timeout_flag,
  input  logic pwr_fail_flag,
  input  logic loop_flag,
  input  logic resume_int,
  output logic if_reset,
  output logic if_enable,
  output logic link_on
);
  localparam longint SHORT_L = (longint'(REF_HZ) * SHORT_NS + 64'd500_000_000) / 64'd1_000_000_000;
  localparam longint LONG_L  = (longint'(REF_HZ) * LONG_NS  + 64'd500_000_000) / 64'd1_000_000_000;
  localparam int SHORT_CYC = int'(SHORT_L);
  localparam int LONG_CYC  = int'(LONG_L);
  localparam int GW = $clog2(LONG_CYC + 1);
  localparam int IW = $clog2(INIT_CYC + 1);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [GW-1:0] gap;
  logic [IW-1:0] up;
  logic [PW-1:0] ph;
  logic          act;
  logic          intr;
  logic          act_nx;

  assign intr   = port_event | ((timeout_flag | pwr_fail_flag | loop_flag) & resume_int);
  assign act_nx = lps ? 1'b0 : (bus_reset ? intr : (act | intr | linkon_pkt));
  assign link_on = act & ph[PW-1];

  always_ff @(posedge clk) begin
    if (!rst_n)                 gap <= '0;
    else if (lps)               gap <= '0;
    else if (gap != GW'(LONG_CYC)) gap <= gap + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if_enable <= 1'b0;
      up        <= '0;
    end else if (!lps) begin
      up <= '0;
      if (gap >= GW'(LONG_CYC - 1)) if_enable <= 1'b0;
    end else if (!if_enable) begin
      if (up == IW'(INIT_CYC - 1)) begin
        if_enable <= 1'b1;
        up        <= '0;
      end else begin
        up <= up + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) if_reset <= 1'b0;
    else        if_reset <= lps & if_enable & (gap >= GW'(SHORT_CYC));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b0;
      ph  <= '0;
    end else begin
      act <= act_nx;
      if (act & act_nx) ph <= ph + 1'b1;
      else              ph <= '0;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (!if_enable && !if_reset && !link_on));

  assert_pulse_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    if_reset |-> if_enable);

  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    if_reset |=> !if_reset);

  assert_disable_on_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(if_enable) |-> $past(!lps));

  assert_enable_on_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(if_enable) |-> $past(lps));

  assert_wake_only_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    link_on |-> $past(!lps));

  assert_wake_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !lps && !bus_reset) |=> act);

  assert_busreset_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!lps && bus_reset && intr) |=> act);
endmodule

// File: tb/sim_link_power_supervisor.sv
module sim_link_power_supervisor;
  localparam int SHORT = 59;
  localparam int LONG  = 1229;
  localparam int INIT  = 64;
  localparam int DIVN  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, lps = 1'b1, linkon_pkt = 1'b0, bus_reset = 1'b0;
  logic port_event = 1'b0, timeout_flag = 1'b0, pwr_fail_flag = 1'b0, loop_flag = 1'b0, resume_int = 1'b0;
  logic if_reset, if_enable, link_on;

  link_power_supervisor u0 (
    .clk(clk), .rst_n(rst_n), .lps(lps), .linkon_pkt(linkon_pkt), .bus_reset(bus_reset),
    .port_event(port_event), .timeout_flag(timeout_flag), .pwr_fail_flag(pwr_fail_flag),
    .loop_flag(loop_flag), .resume_int(resume_int),
    .if_reset(if_reset), .if_enable(if_enable), .link_on(link_on));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  string req = "R1";
  bit done = 0;

  int m_low = 0, m_high = 0, m_ph = 0;
  bit m_en = 0, m_rst = 0, m_act = 0;

  always @(posedge clk) begin
    bit cause, nact, oen;
    int olow;
    cycles++;
    if (!rst_n) begin
      m_low = 0; m_high = 0; m_en = 0; m_rst = 0; m_act = 0; m_ph = 0;
    end else begin
      olow = m_low; oen = m_en;
      cause = port_event || ((timeout_flag || pwr_fail_flag || loop_flag) && resume_int);
      m_rst = lps && oen && olow >= SHORT;
      if (!lps) begin
        m_low = (olow + 1 > LONG) ? LONG : olow + 1;
        m_high = 0;
        if (olow + 1 >= LONG) m_en = 0;
      end else begin
        m_low = 0;
        if (!oen) begin
          m_high++;
          if (m_high == INIT) begin m_en = 1; m_high = 0; end
        end
      end
      if (lps) nact = 0;
      else if (bus_reset) nact = cause;
      else nact = m_act || cause || linkon_pkt;
      m_ph = (m_act && nact) ? (m_ph + 1) % DIVN : 0;
      m_act = nact;
    end
  end

  always @(negedge clk) begin
    bit e_on;
    if (!done) begin
      e_on = m_act && (m_ph >= DIVN/2);
      checks++;
      if (if_reset !== m_rst || if_enable !== m_en || link_on !== e_on) begin
        fails++;
        $display("FAIL %s cycle %0d: rst/en/on actual %b%b%b expected %b%b%b",
                 req, cycles, if_reset, if_enable, link_on, m_rst, m_en, e_on);
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(negedge clk) if (cycles > 150000 && !done) begin
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    req = "R1"; cyc(3); rst_n = 1;
    req = "R4"; cyc(INIT + 5);
    req = "R2"; lps = 0; cyc(30); lps = 1; cyc(5);
    lps = 0; cyc(SHORT - 1); lps = 1; cyc(5);
    lps = 0; cyc(SHORT); lps = 1; cyc(5);
    lps = 0; cyc(300); lps = 1; cyc(5);
    req = "R3"; lps = 0; cyc(LONG + 20); lps = 1; cyc(10); lps = 0; cyc(3);
    req = "R4"; lps = 1; cyc(INIT + 5);
    req = "R11"; linkon_pkt = 1; cyc(1); linkon_pkt = 0; cyc(2); lps = 0; cyc(20);
    req = "R6"; linkon_pkt = 1; cyc(1); linkon_pkt = 0;
    req = "R10"; cyc(30);
    req = "R8"; bus_reset = 1; cyc(1); bus_reset = 0; cyc(10);
    req = "R6"; port_event = 1; cyc(2); port_event = 0;
    req = "R7"; cyc(25);
    req = "R8"; port_event = 1; bus_reset = 1; cyc(1); bus_reset = 0; port_event = 0; cyc(12);
    req = "R7"; lps = 1; cyc(10);
    req = "R9"; timeout_flag = 1; resume_int = 1; cyc(5); lps = 0; cyc(20);
    lps = 1; timeout_flag = 0; resume_int = 0; cyc(3);
    req = "R6"; timeout_flag = 1; lps = 0; cyc(20); timeout_flag = 0;
    loop_flag = 1; resume_int = 1; cyc(12); loop_flag = 0; resume_int = 0;
    pwr_fail_flag = 1; resume_int = 1; lps = 1; cyc(3); lps = 0; cyc(12);
    pwr_fail_flag = 0; resume_int = 0; lps = 1; cyc(5);
    req = "R5"; lps = 0; cyc(LONG + 10); linkon_pkt = 1; cyc(1); linkon_pkt = 0; cyc(20);
    lps = 1; cyc(INIT + 5);
    req = "R1"; lps = 0; port_event = 1; cyc(10); rst_n = 0; cyc(3); port_event = 0; lps = 1; rst_n = 1; cyc(INIT + 5);
    finish_run();
  end
endmodule